// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block is a single latched output channel that hands data from a processor to a peripheral under a three-wire handshake. The processor places a byte in the channel's buffer with an active-low write strobe. When that strobe ends, the block lowers an active-low buffer-full flag. The peripheral takes the byte by pulsing an active-low acknowledge. The falling edge of the acknowledge empties the buffer. The rising edge raises an interrupt request if the control unit has enabled it. The next write clears the request as soon as its strobe goes low.

The acknowledge and write strobes arrive asynchronously. Each one passes through a synchroniser into the system clock domain and is edge-detected there. The control unit supplies three inputs: an interrupt-enable flag, a pulse issued when a new mode word is written, and a bidirectional select. With the bidirectional select set, the port pins are driven only while the acknowledge is low, so that an input channel can share the same pins. The block also provides a three-bit status group for the shared handshake register. In that group the interrupt-enable flag takes the place of the acknowledge pin.

Top module: `strobed_out_port`

## Requirements
- R1: After reset, obf_n is 1, intr is 0, port_out is 0x00 and port_oe is 1 (with bidir = 0).
- R2: obf_n goes low only after the write strobe wr_n has returned high. While wr_n is still low, obf_n keeps its previous value.
- R3: The byte on wr_data while wr_n is low is latched and presented on port_out.
- R4: A falling edge on ack_n sets obf_n back to 1.
- R5: A rising edge on ack_n raises intr when obf_n is 1 and int_en is 1 at that edge.
- R6: intr is cleared by the falling edge of wr_n, before the strobe ends.
- R7: While int_en is 0, intr is 0. Dropping int_en clears a pending intr.
- R8: A mode_load pulse sets obf_n to 1 and intr to 0.
- R9: With bidir = 1, port_oe is 1 only while the synchronised ack_n is low. With bidir = 0, port_oe stays 1 regardless of ack_n.
- R10: stat_bits reads {obf_n, int_en, intr}. Bit 2 holds the buffer-full flag, bit 1 holds the enable flag in the acknowledge slot, and bit 0 holds the interrupt.
- R11: A rising edge on ack_n does not raise intr if a write has completed during the acknowledge pulse and left obf_n at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Processor write strobe for this channel, active low, asynchronous |
| wr_data | input | WIDTH | Processor data bus |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| int_en | input | 1 | Interrupt-enable flag from the control unit |
| mode_load | input | 1 | One-cycle pulse marking a new mode word |
| bidir | input | 1 | 1 selects shared-pin (bidirectional) operation |
| port_out | output | WIDTH | Latched data toward the peripheral |
| port_oe | output | 1 | Tristate enable for the port pins |
| obf_n | output | 1 | Buffer-full flag, active low |
| intr | output | 1 | Interrupt request, active high |
| stat_bits | output | 3 | Status group {obf_n, int_en, intr} |

## Verification
The bench checks obf_n during the low phase of the write strobe. A design that sets buffer-full at the start of the write would fail there. The bench also checks that intr has already fallen while wr_n is still low, which catches a design that clears the request at the end of the write. It completes a write inside an acknowledge pulse, so a design that ignores the buffer-full condition raises a false interrupt. The remaining checks cover three cases: int_en dropping while a request is pending, which a design that only gates the set would leave high; a mode_load pulse that must clear both flags; and bidirectional mode, where a design that never releases the pins would collide with the input channel.

// File: rtl/strobed_out_port.sv
module strobed_out_port #(
  parameter int WIDTH = 8,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             ack_n,
  input  logic             int_en,
  input  logic             mode_load,
  input  logic             bidir,
  output logic [WIDTH-1:0] port_out,
  output logic             port_oe,
  output logic             obf_n,
  output logic             intr,
  output logic [2:0]       stat_bits
);

  logic [SYNC-1:0]  wr_sh, ack_sh;
  logic             wr_d, ack_d;
  logic [WIDTH-1:0] buf_q;

  wire wr_s  = wr_sh[SYNC-1];
  wire ack_s = ack_sh[SYNC-1];

  wire wr_fall  = wr_d & ~wr_s;
  wire wr_rise  = ~wr_d & wr_s;
  wire ack_fall = ack_d & ~ack_s;
  wire ack_rise = ~ack_d & ack_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sh  <= '1;
      ack_sh <= '1;
      wr_d   <= 1'b1;
      ack_d  <= 1'b1;
    end else begin
      wr_sh  <= {wr_sh[SYNC-2:0], wr_n};
      ack_sh <= {ack_sh[SYNC-2:0], ack_n};
      wr_d   <= wr_s;
      ack_d  <= ack_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        buf_q <= '0;
    else if (!wr_n) buf_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || mode_load) obf_n <= 1'b1;
    else if (wr_rise)     obf_n <= 1'b0;
    else if (ack_fall)    obf_n <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || mode_load || !int_en || wr_fall) intr <= 1'b0;
    else if (ack_rise && obf_n)                 intr <= 1'b1;
  end

  assign port_out  = buf_q;
  assign port_oe   = bidir ? ~ack_s : 1'b1;
  assign stat_bits = {obf_n, int_en, intr};

endmodule

module strobed_out_port_chk (
  input logic clk,
  input logic rst,
  input logic int_en,
  input logic mode_load,
  input logic obf_n,
  input logic intr,
  input logic wr_rise,
  input logic wr_fall,
  input logic ack_fall
);

  // R2
  obf_set_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(obf_n) |-> $past(wr_rise));

  // R4
  obf_clear_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(obf_n) |-> $past(ack_fall || mode_load));

  // R5
  intr_raise_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intr) |-> $past(int_en) && $past(obf_n));

  // R6
  intr_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(intr) |-> $past(wr_fall || !int_en || mode_load));

  // R7
  intr_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !intr);

  // R8
  mode_reload_chk: assert property (@(posedge clk) disable iff (rst)
    mode_load |=> obf_n && !intr);

endmodule

bind strobed_out_port strobed_out_port_chk chk_i (
  .clk(clk), .rst(rst), .int_en(int_en), .mode_load(mode_load),
  .obf_n(obf_n), .intr(intr), .wr_rise(wr_rise), .wr_fall(wr_fall),
  .ack_fall(ack_fall)
);

// File: tb/strobed_out_port_tb.sv
module strobed_out_port_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       ack_n = 1'b1;
  logic       int_en = 1'b0;
  logic       mode_load = 1'b0;
  logic       bidir = 1'b0;
  logic [7:0] port_out;
  logic       port_oe, obf_n, intr;
  logic [2:0] stat_bits;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  strobed_out_port dut_i (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_data(wr_data), .ack_n(ack_n),
    .int_en(int_en), .mode_load(mode_load), .bidir(bidir),
    .port_out(port_out), .port_oe(port_oe), .obf_n(obf_n), .intr(intr),
    .stat_bits(stat_bits)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_begin(input logic [7:0] d);
    wr_data = d;
    wr_n = 1'b0;
    wait_n(4);
  endtask

  task automatic wr_end();
    wr_n = 1'b1;
    wait_n(4);
  endtask

  task automatic t_reset();
    check("R1 obf_n", {7'd0, obf_n}, 8'd1);
    check("R1 intr", {7'd0, intr}, 8'd0);
    check("R1 port_out", port_out, 8'h00);
    check("R1 port_oe", {7'd0, port_oe}, 8'd1);
  endtask

  task automatic t_plain_write();
    int_en = 1'b0;
    wr_begin(8'hA5);
    check("R2 obf_n held during strobe", {7'd0, obf_n}, 8'd1);
    wr_end();
    check("R2 obf_n after strobe", {7'd0, obf_n}, 8'd0);
    check("R3 port_out", port_out, 8'hA5);
    check("R10 stat_bits", {5'd0, stat_bits}, 8'b000);
    ack_n = 1'b0; wait_n(4);
    check("R4 obf_n on ack fall", {7'd0, obf_n}, 8'd1);
    ack_n = 1'b1; wait_n(4);
    check("R7 intr disabled", {7'd0, intr}, 8'd0);
  endtask

  task automatic t_interrupt();
    int_en = 1'b1;
    wr_begin(8'h3C); wr_end();
    check("R3 port_out 3C", port_out, 8'h3C);
    ack_n = 1'b0; wait_n(4);
    check("R5 intr low before ack rise", {7'd0, intr}, 8'd0);
    ack_n = 1'b1; wait_n(4);
    check("R5 intr on ack rise", {7'd0, intr}, 8'd1);
    check("R10 stat_bits", {5'd0, stat_bits}, 8'b111);
    wr_begin(8'h5A);
    check("R6 intr cleared at write start", {7'd0, intr}, 8'd0);
    check("R2 obf_n still high", {7'd0, obf_n}, 8'd1);
    wr_end();
    check("R2 obf_n low", {7'd0, obf_n}, 8'd0);
    check("R10 stat_bits", {5'd0, stat_bits}, 8'b010);
  endtask

  task automatic t_full_at_rise();
    int_en = 1'b1;
    ack_n = 1'b0; wait_n(4);
    check("R4 obf_n", {7'd0, obf_n}, 8'd1);
    wr_begin(8'hC3); wr_end();
    check("R11 obf_n full inside ack", {7'd0, obf_n}, 8'd0);
    ack_n = 1'b1; wait_n(4);
    check("R11 no intr while full", {7'd0, intr}, 8'd0);
    check("R3 port_out C3", port_out, 8'hC3);
  endtask

  task automatic t_disable();
    int_en = 1'b1;
    ack_n = 1'b0; wait_n(4);
    ack_n = 1'b1; wait_n(4);
    check("R5 intr set", {7'd0, intr}, 8'd1);
    int_en = 1'b0; wait_n(2);
    check("R7 intr dropped", {7'd0, intr}, 8'd0);
    int_en = 1'b1; wait_n(2);
    check("R7 intr stays low on re-enable", {7'd0, intr}, 8'd0);
  endtask

  task automatic t_mode();
    int_en = 1'b1;
    wr_begin(8'h11); wr_end();
    ack_n = 1'b0; wait_n(4);
    ack_n = 1'b1; wait_n(4);
    check("R5 intr set", {7'd0, intr}, 8'd1);
    mode_load = 1'b1; wait_n(1); mode_load = 1'b0; wait_n(1);
    check("R8 intr cleared", {7'd0, intr}, 8'd0);
    wr_begin(8'h22); wr_end();
    check("R2 obf_n low", {7'd0, obf_n}, 8'd0);
    mode_load = 1'b1; wait_n(1); mode_load = 1'b0; wait_n(1);
    check("R8 obf_n cleared", {7'd0, obf_n}, 8'd1);
  endtask

  task automatic t_bidir();
    bidir = 1'b0;
    ack_n = 1'b0; wait_n(4);
    check("R9 unidir oe during ack", {7'd0, port_oe}, 8'd1);
    ack_n = 1'b1; wait_n(4);
    bidir = 1'b1; wait_n(1);
    check("R9 bidir oe idle", {7'd0, port_oe}, 8'd0);
    ack_n = 1'b0; wait_n(4);
    check("R9 bidir oe during ack", {7'd0, port_oe}, 8'd1);
    ack_n = 1'b1; wait_n(4);
    check("R9 bidir oe released", {7'd0, port_oe}, 8'd0);
    bidir = 1'b0; wait_n(1);
    check("R9 unidir oe restored", {7'd0, port_oe}, 8'd1);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_plain_write();
    t_interrupt();
    t_full_at_rise();
    t_disable();
    t_mode();
    t_bidir();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule